// File: doc/BRIEF.md
# Monochrome Blit Word Datapath

This block is the per-word engine of a one-bit-per-pixel block copier. It works one 16-bit word of a frame store at a time. A host read of a source word moves that word into a two-word shifter. A host write then runs a read-modify-write on the destination word. The source fed to that write is picked by the current mode. In copy mode it is the two shifter words, joined and shifted right by a programmed bit count. In every other mode it is the host's own write data.

The picked source then passes through a source-select stage: all ones, the low bit copied across the word, or the word as it is. Next a 4-bit raster function combines it with the destination word. Last, a per-bit inhibit mask holds destination pixels that must stay unchanged.

Address stepping, display refresh, colour lookup and line drawing belong to other blocks. Software feeds the datapath through four small configuration registers. The frame store is reached through a single-port memory with one cycle of read latency.

Top module: `mono_blit_datapath`

## Requirements
- R1: After reset the block is idle (busy low, no memory strobe). Its settings are: mode 8'hE0 (normal), stored raster register 16'h0003 (copy source), inhibit mask zero, and source select 2'b11. Configuration writes pick the register with cfg_sel: 0 is mode, 1 is raster, 2 is inhibit and 3 is source select.
- R2: A host write accepted while idle holds busy high for exactly three cycles. In the first cycle it reads the addressed word. In the third cycle it writes the merged word back to the same address.
- R3: A host read or write strobe seen while busy is high is ignored. It starts no memory access and changes no word.
- R4: A host read accepted while idle holds busy high for two cycles. It moves the old current shifter word into the previous slot and loads the fetched word as current. host_rdata then shows that word.
- R5: When mode bits [7:5] are 3'b100 (copy mode), the source is the low 16 bits of {previous, current} shifted right by mode bits [3:0]. An earlier read whose own word falls fully out of this window is still needed to fill the previous slot. For any other mode code (normal 3'b111, line 3'b010, others), the host write data is the source.
- R6: The raster register is stored byte-swapped: a write of W stores {W[7:0], W[15:8]}, and bits [3:0] of the stored value form the active code. The code gives per bit: 0 zero, 1 S&D, 2 S&~D, 3 S, 4 ~S&D, 5 D, 6 S^D, 7 S|D, 8 ~(S|D), 9 ~(S^D), A ~D, B S|~D, C ~S, D ~S|D, E ~(S&D), F one.
- R7: Where an inhibit mask bit is 1, the written word keeps the destination bit. Where it is 0, the written word takes the raster result.
- R8: Source select is cfg_wdata[7:6] of a write to register 3. 2'b00 forces the source to all ones. 2'b01 copies source bit 0 into every bit. 2'b11 and 2'b10 pass the source unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| host_rd | input | 1 | Host source-read request |
| host_wr | input | 1 | Host destination-write request |
| host_addr | input | AW | Word address of the host access |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Current shifter word |
| busy | output | 1 | Operation in progress |
| mem_addr | output | AW | Frame store word address |
| mem_re | output | 1 | Frame store read strobe |
| mem_we | output | 1 | Frame store write strobe |
| mem_wdata | output | DW | Frame store write data |
| mem_rdata | input | DW | Frame store read data, one cycle after mem_re |

## Verification
The assertions assume that no configuration register changes while busy is high. The inhibit check compares the written word against the mask in force during the merge, so a mid-operation change would break it. They also assume the frame store returns read data exactly one cycle after mem_re. The bench meets the first assumption because it writes configuration only after waiting for busy to drop, including in the random loop. It meets the second because its own memory model registers the read word on the edge that sees mem_re.

// File: rtl/blit_pkg.sv
package blit_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRD,
        ST_WMRG,
        ST_WWR,
        ST_RRD,
        ST_RCAP
    } blit_st_e;

    localparam logic [2:0] MODE_COPY   = 3'b100;
    localparam logic [7:0] MODE_RESET  = 8'hE0;
    localparam logic [15:0] ROP_RESET  = 16'h0003;
    localparam logic [1:0] SSEL_ONES   = 2'b00;
    localparam logic [1:0] SSEL_REP    = 2'b01;
    localparam logic [1:0] SSEL_RESET  = 2'b11;
endpackage

// File: rtl/blit_align.sv
module blit_align #(
    parameter int DW = 16,
    localparam int SW = $clog2(DW)
) (
    input  logic [DW-1:0] prev_w,
    input  logic [DW-1:0] cur_w,
    input  logic [SW-1:0] shift,
    output logic [DW-1:0] aligned
);
    logic [2*DW-1:0] joined;

    always_comb begin
        joined  = {prev_w, cur_w} >> shift;
        aligned = joined[DW-1:0];
    end
endmodule

// File: rtl/blit_rop.sv
module blit_rop #(
    parameter int DW = 16
) (
    input  logic [3:0]    code,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] inhibit,
    output logic [DW-1:0] merged
);
    // truth table lookup: index {~S,~D} selects a bit of the code
    for (genvar i = 0; i < DW; i++) begin : g_bit
        logic [1:0] idx;
        assign idx       = {~src[i], ~dst[i]};
        assign merged[i] = inhibit[i] ? dst[i] : code[idx];
    end
endmodule

// File: rtl/mono_blit_datapath.sv
module mono_blit_datapath
    import blit_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [15:0]   cfg_wdata,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          busy,
    output logic [AW-1:0] mem_addr,
    output logic          mem_re,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    localparam int SW = $clog2(DW);

    typedef struct packed {
        blit_st_e      st;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdat;
        logic [DW-1:0] prev;
        logic [DW-1:0] cur;
        logic [DW-1:0] dest;
        logic [DW-1:0] res;
        logic [7:0]    mode;
        logic [15:0]   rop;
        logic [DW-1:0] inh;
        logic [1:0]    ssel;
    } blit_state_t;

    blit_state_t q, d;

    logic [DW-1:0] aligned;
    logic [DW-1:0] src_raw;
    logic [DW-1:0] src_sel;
    logic [DW-1:0] merged;

    blit_align #(.DW(DW)) u_align (
        .prev_w  (q.prev),
        .cur_w   (q.cur),
        .shift   (q.mode[SW-1:0]),
        .aligned (aligned)
    );

    always_comb begin
        src_raw = (q.mode[7:5] == MODE_COPY) ? aligned : q.wdat;
        case (q.ssel)
            SSEL_ONES: src_sel = '1;
            SSEL_REP:  src_sel = {DW{src_raw[0]}};
            default:   src_sel = src_raw;
        endcase
    end

    blit_rop #(.DW(DW)) u_rop (
        .code    (q.rop[3:0]),
        .src     (src_sel),
        .dst     (mem_rdata),
        .inhibit (q.inh),
        .merged  (merged)
    );

    always_comb begin
        d = q;
        if (cfg_we) begin
            case (cfg_sel)
                2'd0:    d.mode = cfg_wdata[7:0];
                2'd1:    d.rop  = {cfg_wdata[7:0], cfg_wdata[15:8]};
                2'd2:    d.inh  = cfg_wdata[DW-1:0];
                default: d.ssel = cfg_wdata[7:6];
            endcase
        end
        case (q.st)
            ST_IDLE: begin
                if (host_wr) begin
                    d.st   = ST_WRD;
                    d.addr = host_addr;
                    d.wdat = host_wdata;
                end else if (host_rd) begin
                    d.st   = ST_RRD;
                    d.addr = host_addr;
                end
            end
            ST_WRD:  d.st = ST_WMRG;
            ST_WMRG: begin
                d.dest = mem_rdata;
                d.res  = merged;
                d.st   = ST_WWR;
            end
            ST_WWR:  d.st = ST_IDLE;
            ST_RRD:  d.st = ST_RCAP;
            ST_RCAP: begin
                d.prev = q.cur;
                d.cur  = mem_rdata;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.mode <= MODE_RESET;
            q.rop  <= ROP_RESET;
            q.ssel <= SSEL_RESET;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.st != ST_IDLE);
    assign host_rdata = q.cur;
    assign mem_addr   = q.addr;
    assign mem_re     = (q.st == ST_WRD) || (q.st == ST_RRD);
    assign mem_we     = (q.st == ST_WWR);
    assign mem_wdata  = q.res;

    // R2: a write keeps busy for three cycles, then releases
    a_r2_busy_three: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_wr) |=> busy ##1 busy ##1 busy ##1 !busy);

    // R2: the write-back follows a read of the same word two cycles earlier
    a_r2_rmw_order: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(mem_re, 2) && $past(mem_addr, 2) == mem_addr));

    // R3: requests during busy never start a second back-to-back access
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re);

    // R3: read and write strobes never overlap
    a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R4: a completed read moves the shifter by one word
    a_r4_shift_load: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RCAP) |=> (q.cur == $past(mem_rdata) && q.prev == $past(q.cur)));

    // R7: inhibited bits of the written word equal the fetched destination
    a_r7_inhibit_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (((mem_wdata ^ q.dest) & q.inh) == '0));
endmodule

// File: tb/mono_blit_datapath_tb.sv
module mono_blit_datapath_tb;
    localparam int DW = 16;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [15:0]   cfg_wdata = '0;
    logic          host_rd = 1'b0;
    logic          host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          busy;
    logic [AW-1:0] mem_addr;
    logic          mem_re;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    logic [DW-1:0] bm [64];

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model of the configuration and shifter
    logic [7:0]  m_mode = 8'hE0;
    logic [15:0] m_ropw = 16'h0300;
    logic [15:0] m_inh  = '0;
    logic [1:0]  m_ssel = 2'b11;
    logic [15:0] m_prev = '0;
    logic [15:0] m_cur  = '0;

    always #5 clk = ~clk;

    mono_blit_datapath #(.DW(DW), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy(busy), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we) bm[mem_addr[5:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= bm[mem_addr[5:0]];
    end

    function automatic logic [15:0] rop_f(input logic [3:0] c, input logic [15:0] s,
                                          input logic [15:0] t);
        case (c)
            4'h0: return 16'h0000;
            4'h1: return s & t;
            4'h2: return s & ~t;
            4'h3: return s;
            4'h4: return ~s & t;
            4'h5: return t;
            4'h6: return s ^ t;
            4'h7: return s | t;
            4'h8: return ~(s | t);
            4'h9: return ~(s ^ t);
            4'hA: return ~t;
            4'hB: return s | ~t;
            4'hC: return ~s;
            4'hD: return ~s | t;
            4'hE: return ~(s & t);
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic logic [15:0] expect_f(input logic [15:0] hd, input logic [15:0] dst);
        logic [31:0] j;
        logic [15:0] raw, s, r;
        j   = {m_prev, m_cur} >> m_mode[3:0];
        raw = (m_mode[7:5] == 3'b100) ? j[15:0] : hd;
        case (m_ssel)
            2'b00:   s = 16'hFFFF;
            2'b01:   s = {16{raw[0]}};
            default: s = raw;
        endcase
        r = rop_f(m_ropw[11:8], s, dst);
        return (r & ~m_inh) | (dst & m_inh);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            2'd0:    m_mode = v[7:0];
            2'd1:    m_ropw = v;
            2'd2:    m_inh  = v;
            default: m_ssel = v[7:6];
        endcase
    endtask

    task automatic hread(input int a, output int cyc);
        @(negedge clk);
        host_rd = 1'b1; host_addr = AW'(a);
        @(negedge clk);
        host_rd = 1'b0;
        cyc = 0;
        while (busy) begin cyc++; @(negedge clk); end
        m_prev = m_cur;
        m_cur  = bm[a];
    endtask

    task automatic hwrite(input int a, input logic [15:0] v, output int cyc);
        @(negedge clk);
        host_wr = 1'b1; host_addr = AW'(a); host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
        cyc = 0;
        while (busy) begin cyc++; @(negedge clk); end
    endtask

    task automatic wr_check(input string req, input int a, input logic [15:0] v);
        logic [15:0] e;
        int c;
        e = expect_f(v, bm[a]);
        hwrite(a, v, c);
        check(req, bm[a], e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int c;
        for (int i = 0; i < 64; i++) bm[i] = 16'(i * 16'h1357 + 16'h0A5C);
        repeat (3) @(negedge clk);
        // R1: idle after reset
        check("R1 busy", busy, 0);
        check("R1 strobes", {mem_re, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after release", busy, 0);

        // R1/R2: default settings copy host data with a three-cycle busy
        hwrite(5, 16'hBEEF, c);
        check("R1 default copy", bm[5], 16'hBEEF);
        check("R2 busy cycles", c, 3);
        check("R2 neighbour untouched", bm[6], 16'(6 * 16'h1357 + 16'h0A5C));

        // R4: read loads shifter, two busy cycles
        hread(7, c);
        check("R4 busy cycles", c, 2);
        check("R4 rdata", host_rdata, bm[7]);

        // R5: copy mode with shift 4 after a discarded pre-read
        bm[10] = 16'h1234; bm[11] = 16'hABCD; bm[12] = 16'h5678;
        hread(10, c);
        hread(11, c);
        hread(12, c);
        cfg(2'd0, 16'h0084);
        check("R5 shifted", expect_f(16'h0, 16'h0), 16'hD567);
        wr_check("R5 copy mode shift 4", 20, 16'h0000);
        check("R5 written word", bm[20], 16'hD567);
        cfg(2'd0, 16'h0040);
        wr_check("R5 line mode uses host data", 21, 16'h3C3C);
        check("R5 line mode word", bm[21], 16'h3C3C);
        cfg(2'd0, 16'h00E0);

        // R6: byte-swapped storage of the raster code
        bm[22] = 16'h0FF0;
        cfg(2'd1, 16'h0600);
        wr_check("R6 xor via swapped write", 22, 16'h00FF);
        check("R6 xor word", bm[22], 16'h0F0F);
        cfg(2'd1, 16'h0006);
        wr_check("R6 unswapped write gives zero", 22, 16'hFFFF);
        check("R6 zero word", bm[22], 16'h0000);
        for (int k = 0; k < 16; k++) begin
            cfg(2'd1, {4'h0, 4'(k), 8'h00});
            wr_check($sformatf("R6 code %0h", k), 30 + k, 16'hC3A5);
        end

        // R7: inhibit mask keeps destination bits
        cfg(2'd1, 16'h0300);
        bm[23] = 16'hAAAA;
        cfg(2'd2, 16'hFF00);
        wr_check("R7 inhibit high byte", 23, 16'h1234);
        check("R7 word", bm[23], 16'hAA34);
        cfg(2'd2, 16'h0000);

        // R8: source select
        cfg(2'd3, 16'h0000);
        wr_check("R8 all ones", 24, 16'h0000);
        check("R8 ones word", bm[24], 16'hFFFF);
        cfg(2'd3, 16'h0040);
        wr_check("R8 replicate", 25, 16'h0001);
        check("R8 replicate word", bm[25], 16'hFFFF);
        wr_check("R8 replicate zero", 26, 16'hFFFE);
        check("R8 replicate zero word", bm[26], 16'h0000);
        cfg(2'd3, 16'h00C0);

        // R3: request during busy is ignored
        bm[50] = 16'h7777;
        @(negedge clk);
        host_wr = 1'b1; host_addr = AW'(49); host_wdata = 16'h1111;
        @(negedge clk);
        host_addr = AW'(50); host_wdata = 16'h2222;
        @(negedge clk);
        host_wr = 1'b0;
        while (busy) @(negedge clk);
        check("R3 second request ignored", bm[50], 16'h7777);
        check("R3 first request done", bm[49], 16'h1111);

        // random mix
        void'($urandom(32'd20240611));
        for (int it = 0; it < 200; it++) begin
            logic [7:0] md;
            int nr;
            case ($urandom_range(0, 2))
                0: md = 8'hE0;
                1: md = 8'h80 | 8'($urandom_range(0, 15));
                default: md = 8'h40;
            endcase
            cfg(2'd0, {8'h00, md});
            cfg(2'd1, {4'h0, 4'($urandom_range(0, 15)), 8'($urandom)});
            cfg(2'd2, 16'($urandom));
            cfg(2'd3, {8'h00, 2'($urandom), 6'h0});
            nr = $urandom_range(0, 2);
            for (int r = 0; r < nr; r++) hread($urandom_range(0, 63), c);
            wr_check("R5 R6 R7 R8 random", $urandom_range(0, 63), 16'($urandom));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule